// File: doc/BRIEF.md
# Eight-Line Prioritized Interrupt Controller

This block merges eight peripheral interrupt request lines into one interrupt signal for a processor. Each line is latched into a pending-request register. A software-writable mask register keeps chosen lines away from the processor. A fixed-priority resolver selects the most urgent unmasked pending line, with line 0 the most urgent and line 7 the least.

When the processor acknowledges, the chosen line moves from pending to in-service, and the block presents an 8-bit vector. The vector is made of a programmable 5-bit base and the 3-bit line number. While a line is in service, the interrupt output stays low for that line and for every less urgent line. A more urgent line may still nest on top of it. Software writes an end-of-interrupt command to close the most urgent in-service level.

Each line can be set to edge or level triggering. A small register port writes the mask, the trigger modes, the vector base and the command. The same port reads back the mask, the trigger modes, the pending register and the in-service register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the mask register reads 0xFF (all lines masked), trigger mode reads 0x00 (all edge), the pending and in-service registers read 0x00, `int_out` and `vec_valid` are low, and `vec_out` is 0x00.
- R2: Edge mode (trigger bit 0): a rising edge on line n sets pending bit n at the next clock. The bit stays set after the input falls. Once acknowledge has cleared it, the bit stays clear while the input is held high, until a new low-to-high transition occurs.
- R3: Level mode (trigger bit 1): pending bit n equals the line-n input sampled at the previous clock edge.
- R4: A set mask bit keeps its line from raising `int_out` or being granted. The pending bit is still recorded, and clearing the mask bit later lets the request through.
- R5: Among unmasked pending lines, the lowest-numbered line is the one granted on acknowledge.
- R6: An `int_ack` pulse while `int_out` is high does four things at that clock edge: it sets the in-service bit of the granted line, clears its pending bit (edge mode), drives `vec_out` to {base[4:0], line[2:0]}, and pulses `vec_valid` high for one cycle. `vec_out` holds until the next grant.
- R7: `int_out` is high only when some unmasked pending line is numbered strictly lower than every set in-service bit. An equal or higher-numbered pending line leaves it low.
- R8: An `int_ack` pulse while `int_out` is low is ignored. The in-service register, `vec_out` and `vec_valid` do not change.
- R9: Writing address 3 with data bit 7 set is a non-specific end-of-interrupt. It clears only the lowest-numbered set in-service bit.
- R10: Register map, with all writes taking effect at the clock edge. Address 0 writes and reads the mask. Address 1 writes and reads the trigger modes. Writing address 2 sets the base from data bits 7:3, and reading address 2 returns the pending register. Reading address 3 returns the in-service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Peripheral request lines, bit n is line n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge from the processor |
| vec_out | output | 8 | Vector of the last granted line |
| vec_valid | output | 1 | One-cycle pulse after a grant |

## Verification
Edge triggering is first driven with a single held line. This separates true edge capture from level following, and shows that a held input does not re-request after acknowledge. Simultaneous requests on two lines expose the fixed priority. A more urgent line arriving during service shows nesting, and a less urgent line pending during service shows blocking. Two end-of-interrupt writes in a row confirm that only the most urgent in-service bit clears each time. Masked edges, level-mode toggling and an acknowledge with nothing pending round out the set, separating mask filtering, level following and ignored handshakes.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   typedef enum logic [1:0] {
      RA_MASK     = 2'd0,
      RA_TRIG     = 2'd1,
      RA_BASE_IRR = 2'd2,
      RA_CMD_ISR  = 2'd3
   } reg_addr_e;

   localparam int CMD_EOI_BIT = 7;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_req,
   input  logic [NUM_LINES-1:0] level_mode,
   input  logic [NUM_LINES-1:0] clr_oh,
   output logic [NUM_LINES-1:0] irr
);
   logic [NUM_LINES-1:0] irq_d;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_d <= '0;
      else        irq_d <= irq_req;
   end

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irr[n] <= 1'b0;
         end else if (level_mode[n]) begin
            irr[n] <= irq_req[n];
         end else if (irq_req[n] && !irq_d[n]) begin
            irr[n] <= 1'b1;
         end else if (clr_oh[n]) begin
            irr[n] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
   parameter int NUM_LINES = 8,
   localparam int LVL_W    = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] irr,
   input  logic [NUM_LINES-1:0] imr,
   input  logic [NUM_LINES-1:0] isr,
   output logic                 grant_vld,
   output logic [NUM_LINES-1:0] grant_oh,
   output logic [LVL_W-1:0]     grant_idx
);
   localparam logic [NUM_LINES-1:0] ONE_L = NUM_LINES'(1);

   logic [NUM_LINES-1:0] cand;
   logic [NUM_LINES-1:0] isr_low;
   logic [NUM_LINES-1:0] above;
   logic [NUM_LINES-1:0] allowed;

   always_comb begin
      cand     = irr & ~imr;
      isr_low  = isr & (~isr + ONE_L);
      above    = isr_low - ONE_L;
      allowed  = cand & above;
      grant_oh = allowed & (~allowed + ONE_L);
      grant_vld = |allowed;
      grant_idx = '0;
      for (int k = NUM_LINES - 1; k >= 0; k--) begin
         if (allowed[k]) grant_idx = LVL_W'(k);
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int VEC_W     = 8,
   parameter int DATA_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_req,
   input  logic                 reg_we,
   input  logic [1:0]           reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 int_out,
   input  logic                 int_ack,
   output logic [VEC_W-1:0]     vec_out,
   output logic                 vec_valid
);
   localparam int LVL_W  = $clog2(NUM_LINES);
   localparam int BASE_W = VEC_W - LVL_W;
   localparam logic [NUM_LINES-1:0] ONE_L = NUM_LINES'(1);

   if ((1 << LVL_W) != NUM_LINES || NUM_LINES < 2) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (BASE_W < 1 || DATA_W < VEC_W || DATA_W < NUM_LINES) begin : g_bad_width
      $error("VEC_W or DATA_W too narrow for NUM_LINES");
   end

   logic [NUM_LINES-1:0] imr_q, lvl_q, isr_q, irr, grant_oh, clr_oh;
   logic [NUM_LINES-1:0] isr_low;
   logic [BASE_W-1:0]    base_q;
   logic [LVL_W-1:0]     grant_idx;
   logic                 grant_vld, ack_take, eoi_cmd, wr_mask, wr_trig, wr_base;
   logic [VEC_W-1:0]     vec_q;
   logic                 vec_vld_q;

   assign ack_take = int_ack && grant_vld;
   assign clr_oh   = ack_take ? grant_oh : '0;
   assign wr_mask  = reg_we && (reg_addr == RA_MASK);
   assign wr_trig  = reg_we && (reg_addr == RA_TRIG);
   assign wr_base  = reg_we && (reg_addr == RA_BASE_IRR);
   assign eoi_cmd  = reg_we && (reg_addr == RA_CMD_ISR) && reg_wdata[CMD_EOI_BIT];
   assign isr_low  = isr_q & (~isr_q + ONE_L);

   irq_req_latch #(.NUM_LINES(NUM_LINES)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_req    (irq_req),
      .level_mode (lvl_q),
      .clr_oh     (clr_oh),
      .irr        (irr)
   );

   irq_prio_resolver #(.NUM_LINES(NUM_LINES)) u_resolver (
      .irr       (irr),
      .imr       (imr_q),
      .isr       (isr_q),
      .grant_vld (grant_vld),
      .grant_oh  (grant_oh),
      .grant_idx (grant_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr_q  <= '1;
         lvl_q  <= '0;
         base_q <= '0;
      end else begin
         if (wr_mask) imr_q  <= reg_wdata[NUM_LINES-1:0];
         if (wr_trig) lvl_q  <= reg_wdata[NUM_LINES-1:0];
         if (wr_base) base_q <= reg_wdata[VEC_W-1:LVL_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q     <= '0;
         vec_q     <= '0;
         vec_vld_q <= 1'b0;
      end else begin
         isr_q     <= (eoi_cmd ? (isr_q & ~isr_low) : isr_q) | clr_oh;
         vec_vld_q <= ack_take;
         if (ack_take) vec_q <= {base_q, grant_idx};
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_MASK:     reg_rdata[NUM_LINES-1:0] = imr_q;
         RA_TRIG:     reg_rdata[NUM_LINES-1:0] = lvl_q;
         RA_BASE_IRR: reg_rdata[NUM_LINES-1:0] = irr;
         default:     reg_rdata[NUM_LINES-1:0] = isr_q;
      endcase
   end

   assign int_out   = grant_vld;
   assign vec_out   = vec_q;
   assign vec_valid = vec_vld_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int NUM_LINES = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 int_ack,
   input logic                 int_out,
   input logic                 vec_valid,
   input logic                 eoi,
   input logic [NUM_LINES-1:0] isr,
   input logic [NUM_LINES-1:0] irr,
   input logic [NUM_LINES-1:0] imr
);
   // R4: interrupt only with some unmasked pending line
   a_r4_mask_filter: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> |(irr & ~imr));

   // R7: line 0 in service blocks every request
   a_r7_top_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      isr[0] |-> !int_out);

   // R6: accepted acknowledge gives a vector pulse
   a_r6_vec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_out) |=> vec_valid);

   // R8: no pulse without an accepted acknowledge
   a_r8_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !(int_ack && int_out) |=> !vec_valid);

   // R8: ignored acknowledge leaves in-service untouched
   a_r8_isr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && !int_out && !eoi) |=> $stable(isr));

   // R6: accepted acknowledge adds exactly one in-service bit
   a_r6_isr_grow: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_out && !eoi) |=> $countones(isr) == $past($countones(isr)) + 1);

   // R9: end-of-interrupt removes at most one in-service bit
   a_r9_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !(int_ack && int_out) && isr != '0) |=>
         $countones(isr) + 1 == $past($countones(isr)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .int_ack   (int_ack),
   .int_out   (int_out),
   .vec_valid (vec_valid),
   .eoi       (eoi_cmd),
   .isr       (isr_q),
   .irr       (irr),
   .imr       (imr_q)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_req = '0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       int_out;
   logic       int_ack = 1'b0;
   logic [7:0] vec_out;
   logic       vec_valid;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   irq_prio_ctrl i_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .int_out(int_out), .int_ack(int_ack), .vec_out(vec_out),
      .vec_valid(vec_valid)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic ack();
      int_ack = 1'b1;
      tick();
      int_ack = 1'b0;
   endtask

   task automatic t_reset();
      rd_chk("R1 mask", 2'd0, 8'hFF);
      rd_chk("R1 trig", 2'd1, 8'h00);
      rd_chk("R1 irr", 2'd2, 8'h00);
      rd_chk("R1 isr", 2'd3, 8'h00);
      chk("R1 int_out", {7'd0, int_out}, 8'h00);
      chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
      chk("R1 vec_out", vec_out, 8'h00);
   endtask

   task automatic t_edge();
      wr(2'd0, 8'h00);
      wr(2'd2, 8'hA0);
      rd_chk("R10 mask readback", 2'd0, 8'h00);
      irq_req[3] = 1'b1; tick();
      rd_chk("R2 edge latch", 2'd2, 8'h08);
      chk("R2 int_out", {7'd0, int_out}, 8'h01);
      irq_req[3] = 1'b0; tick();
      rd_chk("R2 held after fall", 2'd2, 8'h08);
      ack();
      chk("R6 vector", vec_out, 8'hA3);
      chk("R6 vec_valid", {7'd0, vec_valid}, 8'h01);
      rd_chk("R6 irr cleared", 2'd2, 8'h00);
      rd_chk("R6 isr set", 2'd3, 8'h08);
      tick();
      chk("R6 vec_valid one cycle", {7'd0, vec_valid}, 8'h00);
      chk("R6 vec_out holds", vec_out, 8'hA3);
      irq_req[3] = 1'b1; tick();
      chk("R7 equal level blocked", {7'd0, int_out}, 8'h00);
      wr(2'd3, 8'h80);
      rd_chk("R9 eoi clears", 2'd3, 8'h00);
      chk("R7 unblocked", {7'd0, int_out}, 8'h01);
      ack();
      tick(); tick();
      rd_chk("R2 no re-request while held", 2'd2, 8'h00);
      irq_req[3] = 1'b0;
      wr(2'd3, 8'h80);
      tick();
   endtask

   task automatic t_level();
      wr(2'd1, 8'h10);
      rd_chk("R10 trig readback", 2'd1, 8'h10);
      irq_req[4] = 1'b1; tick();
      rd_chk("R3 level high", 2'd2, 8'h10);
      irq_req[4] = 1'b0; tick();
      rd_chk("R3 level low", 2'd2, 8'h00);
      chk("R3 int_out low", {7'd0, int_out}, 8'h00);
      wr(2'd1, 8'h00);
   endtask

   task automatic t_mask();
      wr(2'd0, 8'h02);
      wr(2'd2, 8'h58);
      irq_req[1] = 1'b1; tick();
      irq_req[1] = 1'b0;
      rd_chk("R4 masked still recorded", 2'd2, 8'h02);
      chk("R4 masked no int", {7'd0, int_out}, 8'h00);
      wr(2'd0, 8'h00);
      chk("R4 unmasked int", {7'd0, int_out}, 8'h01);
      ack();
      chk("R6 new base vector", vec_out, 8'h59);
      wr(2'd3, 8'h80);
      wr(2'd2, 8'hA0);
   endtask

   task automatic t_prio();
      irq_req = 8'h24; tick();
      irq_req = 8'h00;
      rd_chk("R5 both pending", 2'd2, 8'h24);
      ack();
      chk("R5 lowest line wins", vec_out, 8'hA2);
      rd_chk("R5 other still pending", 2'd2, 8'h20);
      chk("R7 lower level blocked", {7'd0, int_out}, 8'h00);
      irq_req[0] = 1'b1; tick();
      irq_req[0] = 1'b0;
      chk("R7 higher level nests", {7'd0, int_out}, 8'h01);
      ack();
      chk("R6 nested vector", vec_out, 8'hA0);
      rd_chk("R6 nested isr", 2'd3, 8'h05);
      wr(2'd3, 8'h80);
      rd_chk("R9 clears lowest only", 2'd3, 8'h04);
      chk("R7 still blocked by 2", {7'd0, int_out}, 8'h00);
      wr(2'd3, 8'h80);
      rd_chk("R9 second eoi", 2'd3, 8'h00);
      chk("R7 line 5 now allowed", {7'd0, int_out}, 8'h01);
      ack();
      chk("R5 line 5 vector", vec_out, 8'hA5);
      wr(2'd3, 8'h80);
   endtask

   task automatic t_idle_ack();
      chk("R8 idle int_out", {7'd0, int_out}, 8'h00);
      ack();
      chk("R8 no vec_valid", {7'd0, vec_valid}, 8'h00);
      chk("R8 vec_out unchanged", vec_out, 8'hA5);
      rd_chk("R8 isr unchanged", 2'd3, 8'h00);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_edge();
      t_level();
      t_mask();
      t_prio();
      t_idle_ack();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule